// File: doc/BRIEF.md
# Multi-Channel DMA Priority Arbiter

This block decides which of several DMA channels owns the single shared bus master port for the next data transfer. Every channel is qualified each cycle: it competes only when it is switched on, still has data left to move, and either its peripheral request line is high or it is configured for memory-to-memory copying. The data transfer is always a single item: one read followed by one write. Among the qualified channels, the one with the highest 2-bit software level wins. When levels are equal, the lower channel index wins.

A grant lasts for exactly one single-item transfer. The datapath pulses a done strobe when the write has finished. The grant then drops for one cycle and all channels are arbitrated again, so a long block transfer never keeps the bus. A memory-to-memory channel would otherwise request without pause. To stop it from starving the other channels, it is stepped over for one arbitration after each of its transfers whenever another channel is waiting. This applies even when the waiting channel has a lower level.

Top module: `dma_chan_arbiter`

## Requirements
- R1: A channel competes only when its enable bit is 1, its count-non-zero bit is 1, and either its peripheral request bit or its memory-to-memory bit is 1. Channels failing any of these are never granted.
- R2: Among competing channels, the one with the numerically largest level wins. The level of channel i sits in bits [2i+1:2i] of the level bus, with 11 highest and 00 lowest.
- R3: Among competing channels at the same level, the lowest channel index wins.
- R4: The grant vector is zero or one-hot. When a grant is valid, its single set bit is at the position given by the grant index. When nothing is granted, the grant vector is all zeros and the valid output is 0.
- R5: Once issued, a grant stays unchanged, whatever the requests and levels do, until the done strobe is sampled high.
- R6: Grant timing follows a fixed sequence:
  - From idle, a grant appears at the first clock edge at which some channel competes.
  - After done is sampled with a grant active, the grant is withdrawn at that edge.
  - The next grant can appear one edge later at the earliest.
- R7: After a transfer for a memory-to-memory channel, the following arbitration excludes that channel if any other channel competes. This holds even when the other channel has a lower level.
- R8: A memory-to-memory channel that is the only competitor is granted again at every arbitration.
- R9: During and right after reset, no grant is driven.
- R10: A done strobe while no grant is active has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_req | input | NUM_CH | Peripheral request per channel |
| chan_en | input | NUM_CH | Channel enable per channel |
| chan_m2m | input | NUM_CH | Memory-to-memory mode per channel |
| chan_cnt_nz | input | NUM_CH | Remaining count is non-zero, per channel |
| chan_lvl | input | NUM_CH*2 | Software level, channel i in bits [2i+1:2i] |
| xfer_done | input | 1 | Single transfer finished strobe |
| grant_vld | output | 1 | A grant is active |
| grant_oh | output | NUM_CH | One-hot grant |
| grant_idx | output | IDX_W | Index of the granted channel |

## Verification
Several corner cases are targeted, each with a visible failure mode:
- **Ties at equal level:** a design that scanned channels in the wrong order would hand the bus to the higher index.
- **Unqualified channels:** channels that are disabled or have a zero count still raise requests. A qualifier that ignored enable or count would grant them.
- **Grant hold:** a granted channel drops its request and a very-high channel appears mid-transfer. A design that re-arbitrated before done would switch the grant early.
- **Alternation:** a very-high memory-to-memory channel shares the bus with a low peripheral channel. Without the yield step, the peripheral would never be granted; with a yield that never expires, a lone memory-to-memory channel would stall.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int LVL_W = 2;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/dma_arb_req_qual.sv
module dma_arb_req_qual #(
  parameter int NUM_CH = 7
) (
  input  logic [NUM_CH-1:0] chan_req,
  input  logic [NUM_CH-1:0] chan_en,
  input  logic [NUM_CH-1:0] chan_m2m,
  input  logic [NUM_CH-1:0] chan_cnt_nz,
  output logic [NUM_CH-1:0] elig
);
  // R1: a channel competes when enabled, with data left, and triggered
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign elig[g] = chan_en[g] & chan_cnt_nz[g] & (chan_req[g] | chan_m2m[g]);
  end
endmodule

// File: rtl/dma_arb_prio_sel.sv
module dma_arb_prio_sel
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 7,
  parameter int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0]       cand,
  input  logic [NUM_CH*LVL_W-1:0] lvl_flat,
  output logic                    win_vld,
  output logic [IDX_W-1:0]        win_idx,
  output logic [NUM_CH-1:0]       win_oh
);
  lvl_t lvl [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_unpack
    assign lvl[g] = lvl_flat[g*LVL_W +: LVL_W];
  end

  // Scan from the top index down; ">=" lets a lower index take ties (R2, R3)
  always_comb begin
    lvl_t best;
    win_vld = 1'b0;
    win_idx = '0;
    best    = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (cand[i] && (!win_vld || lvl[i] >= best)) begin
        win_vld = 1'b1;
        win_idx = IDX_W'(i);
        best    = lvl[i];
      end
    end
  end

  assign win_oh = win_vld ? (NUM_CH'(1) << win_idx) : '0;
endmodule

// File: rtl/dma_arb_yield.sv
module dma_arb_yield #(
  parameter int NUM_CH = 7,
  parameter int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [IDX_W-1:0]  set_idx,
  input  logic              clr_en,
  output logic [NUM_CH-1:0] yield_mask
);
  logic [NUM_CH-1:0] mask_q, mask_d;

  always_comb begin
    mask_d = mask_q;
    if (set_en)      mask_d = NUM_CH'(1) << set_idx;
    else if (clr_en) mask_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  assign yield_mask = mask_q;

  p_yield_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mask_q));
endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 7,
  parameter int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CH-1:0]       chan_req,
  input  logic [NUM_CH-1:0]       chan_en,
  input  logic [NUM_CH-1:0]       chan_m2m,
  input  logic [NUM_CH-1:0]       chan_cnt_nz,
  input  logic [NUM_CH*LVL_W-1:0] chan_lvl,
  input  logic                    xfer_done,
  output logic                    grant_vld,
  output logic [NUM_CH-1:0]       grant_oh,
  output logic [IDX_W-1:0]        grant_idx
);
  logic [NUM_CH-1:0] elig, yield_mask, others, cand, win_oh;
  logic              win_vld, issue, finish, yield_set, yield_clr;
  logic [IDX_W-1:0]  win_idx;

  logic              busy_q, busy_d;
  logic [NUM_CH-1:0] oh_q, oh_d;
  logic [IDX_W-1:0]  idx_q, idx_d;

  dma_arb_req_qual #(.NUM_CH(NUM_CH)) u_qual (
    .chan_req    (chan_req),
    .chan_en     (chan_en),
    .chan_m2m    (chan_m2m),
    .chan_cnt_nz (chan_cnt_nz),
    .elig        (elig)
  );

  // R7: skip the last memory-to-memory winner when someone else waits
  assign others = elig & ~yield_mask;
  assign cand   = (|others) ? others : elig;

  dma_arb_prio_sel #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_sel (
    .cand     (cand),
    .lvl_flat (chan_lvl),
    .win_vld  (win_vld),
    .win_idx  (win_idx),
    .win_oh   (win_oh)
  );

  assign issue     = !busy_q && win_vld;
  assign finish    = busy_q && xfer_done;
  assign yield_set = finish && chan_m2m[idx_q];
  assign yield_clr = issue || (!busy_q && !(|elig));

  dma_arb_yield #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_yield (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_en     (yield_set),
    .set_idx    (idx_q),
    .clr_en     (yield_clr),
    .yield_mask (yield_mask)
  );

  // Grant holder: load on issue, release on done (R5, R6, R10)
  always_comb begin
    busy_d = busy_q;
    oh_d   = oh_q;
    idx_d  = idx_q;
    if (issue) begin
      busy_d = 1'b1;
      oh_d   = win_oh;
      idx_d  = win_idx;
    end else if (finish) begin
      busy_d = 1'b0;
      oh_d   = '0;
      idx_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      oh_q   <= '0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      oh_q   <= oh_d;
      idx_q  <= idx_d;
    end
  end

  assign grant_vld = busy_q;
  assign grant_oh  = oh_q;
  assign grant_idx = idx_q;

  p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_oh) && (grant_vld == (|grant_oh)));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld && !xfer_done) |=> (grant_vld && $stable(grant_oh)));

  p_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld && xfer_done) |=> !grant_vld);

  p_eligible_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_vld) |-> (|($past(elig) & grant_oh)));

  p_yield_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && (|(elig & ~yield_mask))) |-> !(|(win_oh & yield_mask)));

  p_idle_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_vld && !win_vld) |=> !grant_vld);
endmodule

// File: tb/dma_chan_arbiter_tb.sv
module dma_chan_arbiter_tb;
  localparam int N = 7;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  chan_req, chan_en, chan_m2m, chan_cnt_nz;
  logic [2*N-1:0] chan_lvl;
  logic          xfer_done;
  logic          grant_vld;
  logic [N-1:0]  grant_oh;
  logic [IW-1:0] grant_idx;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  dma_chan_arbiter #(.NUM_CH(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .chan_req(chan_req), .chan_en(chan_en),
    .chan_m2m(chan_m2m), .chan_cnt_nz(chan_cnt_nz), .chan_lvl(chan_lvl),
    .xfer_done(xfer_done), .grant_vld(grant_vld), .grant_oh(grant_oh),
    .grant_idx(grant_idx)
  );

  typedef struct packed {
    logic [N-1:0]   req;
    logic [N-1:0]   en;
    logic [N-1:0]   m2m;
    logic [N-1:0]   nz;
    logic [2*N-1:0] lvl;
    logic           vld;
    logic [IW-1:0]  idx;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{7'b0000001, 7'h7F, 7'h00, 7'h7F, 14'b00_00_00_00_00_00_00, 1'b1, 3'd0}, // R3 single
    '{7'b1000010, 7'h7F, 7'h00, 7'h7F, 14'b00_00_00_00_00_00_00, 1'b1, 3'd1}, // R3 tie
    '{7'b1000010, 7'h7F, 7'h00, 7'h7F, 14'b11_00_00_00_00_00_00, 1'b1, 3'd6}, // R2 level
    '{7'b0101000, 7'h7F, 7'h00, 7'h7F, 14'b00_01_00_01_00_00_00, 1'b1, 3'd3}, // R3 tie at 01
    '{7'b1111111, 7'h7F, 7'h00, 7'h7F, 14'b01_00_10_00_10_00_00, 1'b1, 3'd2}, // R2 many
    '{7'b0000011, 7'h7E, 7'h00, 7'h7F, 14'b00_00_00_00_00_00_00, 1'b1, 3'd1}, // R1 disabled
    '{7'b0000011, 7'h7F, 7'h00, 7'h7E, 14'b00_00_00_00_00_00_00, 1'b1, 3'd1}, // R1 zero count
    '{7'b0000000, 7'h7F, 7'h10, 7'h7F, 14'b00_00_00_00_00_00_00, 1'b1, 3'd4}, // R1 m2m trigger
    '{7'b0000100, 7'h7B, 7'h00, 7'h7F, 14'b00_00_00_00_00_00_00, 1'b0, 3'd0}, // R1 none
    '{7'b1111111, 7'h7F, 7'h00, 7'h00, 14'b11_11_11_11_11_11_11, 1'b0, 3'd0}  // R1 all zero count
  };

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic check(string tag, logic ev, logic [IW-1:0] ei);
    logic [N-1:0] eoh;
    eoh = ev ? (N'(1) << ei) : '0;
    n_chk++;
    if (grant_vld !== ev || grant_oh !== eoh || (ev && grant_idx !== ei)) begin
      n_bad++;
      $display("FAIL %s: vld=%0b oh=%b idx=%0d expected vld=%0b oh=%b idx=%0d",
               tag, grant_vld, grant_oh, grant_idx, ev, eoh, ei);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_inputs();
    chan_req = '0; chan_en = '0; chan_m2m = '0; chan_cnt_nz = '0;
    chan_lvl = '0; xfer_done = 1'b0;
  endtask

  task automatic finish_xfer();
    xfer_done = 1'b1;
    step();
    xfer_done = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    summary();
  end

  initial begin
    clear_inputs();
    rst_n = 1'b0;
    chan_req = '1; chan_en = '1; chan_cnt_nz = '1;
    repeat (3) @(negedge clk);
    check("R9 in reset", 1'b0, 0);
    clear_inputs();
    rst_n = 1'b1;
    step();
    check("R9 after reset", 1'b0, 0);

    // Vector table: one arbitration from idle per entry
    for (int v = 0; v < NV; v++) begin
      chan_req = VECS[v].req; chan_en = VECS[v].en; chan_m2m = VECS[v].m2m;
      chan_cnt_nz = VECS[v].nz; chan_lvl = VECS[v].lvl;
      step();
      check($sformatf("R1 R2 R3 R4 vector %0d", v), VECS[v].vld, VECS[v].idx);
      clear_inputs();
      finish_xfer();
      check($sformatf("R6 R10 release %0d", v), 1'b0, 0);
      step();
    end

    // R5: grant held while requests and levels change
    chan_en = '1; chan_cnt_nz = '1;
    chan_req = 7'b0001000;
    step();
    check("R5 initial grant", 1'b1, 3);
    chan_req = 7'b0000001;
    chan_lvl = 14'b00_00_00_00_00_00_11;
    repeat (4) begin
      step();
      check("R5 hold", 1'b1, 3);
    end
    // R6: withdrawal at done edge, new grant one edge later
    finish_xfer();
    check("R6 gap cycle", 1'b0, 0);
    step();
    check("R6 next grant", 1'b1, 0);
    clear_inputs();
    finish_xfer();
    step();

    // R7: very-high m2m ch0 alternates with low peripheral ch5
    chan_en = '1; chan_cnt_nz = '1;
    chan_m2m = 7'b0000001;
    chan_req = 7'b0100000;
    chan_lvl = 14'b00_00_00_00_00_00_11;
    step();
    check("R7 m2m first", 1'b1, 0);
    finish_xfer();
    check("R7 gap", 1'b0, 0);
    step();
    check("R7 yield to lower", 1'b1, 5);
    finish_xfer();
    step();
    check("R7 back to m2m", 1'b1, 0);
    finish_xfer();
    step();
    check("R7 alternate again", 1'b1, 5);
    clear_inputs();
    finish_xfer();
    step();

    // R8: lone m2m channel served repeatedly
    chan_en = '1; chan_cnt_nz = '1;
    chan_m2m = 7'b0000100;
    step();
    check("R8 first", 1'b1, 2);
    finish_xfer();
    step();
    check("R8 repeat", 1'b1, 2);
    finish_xfer();
    step();
    check("R8 repeat again", 1'b1, 2);
    clear_inputs();
    finish_xfer();
    step();

    // R10: done while idle is ignored
    xfer_done = 1'b1;
    step();
    check("R10 done idle", 1'b0, 0);
    xfer_done = 1'b0;
    chan_en = '1; chan_cnt_nz = '1; chan_req = 7'b1000000;
    step();
    check("R10 normal after", 1'b1, 6);
    step();
    check("R10 R5 still held", 1'b1, 6);

    summary();
  end
endmodule